// File: doc/BRIEF.md
# PCI Type-0 Configuration Address Translator

This block sits behind a CPU-side configuration window and turns each access that lands there into a standard type-0 PCI configuration address. The 16 low offset bits of the CPU access are joined with a 16-bit upper half that software keeps in a mapping register. The upper 21 bits of the joined word act as a one-hot device-select field, and the position of its lowest set bit becomes the device number. The function and register fields are taken directly from the low bits. The result is a bus/device/function/register address with the enable bit set. The bus number comes from a static input.

An access is refused when the mapping register asks for a type-1 cycle, or when the device-select field is all zero. A refused write is dropped without any trace. A refused read gets an all-ones response that matches the access width. Every accepted access also produces a one-cycle request that clears the received master-abort and target-abort status bits in the host bridge. The translation is combinational and is registered once, so all results appear one clock after the access strobe. The PCI bus cycle and the data path are handled elsewhere.

Top module: `pcicfg_xlate`

## Requirements
- R1: While reset is asserted and after it is released, `cfg_vld`, `fill_vld` and `abort_clr` are 0 until an access is presented.
- R2: The working address is `{map_upper, acc_off}`. The device number is the index, from 0 to 20, of the lowest set bit among working bits [31:11].
- R3: `cfg_addr` carries 1 in bit 31 and 0 in bits [30:24]. The device number sits in [15:11] and working bits [10:8] (function) sit in [10:8]. Working bits [7:2] sit in [7:2], and bits [1:0] are 0.
- R4: `cfg_addr[23:16]` equals `bus_num` as sampled with the access.
- R5: An access with `map_type1` = 1 is refused, whatever its address.
- R6: An access whose working bits [31:11] are all zero is refused.
- R7: A refused write (`acc_wr` = 1) produces no `cfg_vld`, no `fill_vld` and no `abort_clr`.
- R8: A refused read raises `fill_vld` for one cycle. `fill_data` is 0x000000FF when `acc_size` = 0 (1 byte), 0x0000FFFF when it is 1 (2 bytes), and 0xFFFFFFFF when it is 2 or 3 (4 bytes).
- R9: Each accepted read or write raises `abort_clr` for exactly one cycle, in the same cycle as `cfg_vld`. A refused access never raises it.
- R10: All outputs for an access appear in the cycle after `acc_vld`, and `cfg_wr` repeats `acc_wr`. A cycle without `acc_vld` produces no pulse, even right after a pulse.
- R11: When several device-select bits are set, the lowest one decides the device number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 16 | Offset of the access inside the window |
| acc_size | input | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| map_upper | input | 16 | Upper half of the working address, taken from the mapping register |
| map_type1 | input | 1 | Mapping register type-1 request flag |
| bus_num | input | 8 | Static PCI bus number |
| cfg_vld | output | 1 | Translated address is valid this cycle |
| cfg_wr | output | 1 | Direction of the translated access |
| cfg_addr | output | 32 | Type-0 configuration address with enable bit |
| fill_vld | output | 1 | All-ones response for a refused read |
| fill_data | output | 32 | Width-sized all-ones read data |
| abort_clr | output | 1 | Request to clear received master/target abort status |

## Verification
Two outcomes can arrive on consecutive clock edges: the address-plus-clear pair from one access, and the all-ones fill from a refused read presented on the very next cycle. The two can also swap order. Both orders are produced by running the sweeps with no idle cycles, alternating accepted and refused accesses in both directions. In every cycle, the full set of pulses is compared with the result computed for the single access presented one cycle earlier, so a pulse that lingers or leaks from a neighbouring access shows up as a mismatch. A type-1 request combined with an empty device-select field is also presented to confirm that it yields exactly one refusal.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

   // access width code presented with each access
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_WIDE = 2'b11
   } acc_size_e;

   // per-access outcome pulses, registered together
   typedef struct packed {
      logic cfg;
      logic fill;
      logic clr;
   } outcome_t;

endpackage

// File: rtl/pcicfg_tz_enc.sv
// Lowest-set-bit position encoder for the device-select field.
module pcicfg_tz_enc #(
   parameter int SEL_W   = 21,
   parameter int IDX_W   = 5,
   parameter bit TZ_TREE = 1'b1
) (
   input  logic [SEL_W-1:0] sel,
   output logic [IDX_W-1:0] idx,
   output logic             none
);

   initial begin
      assert (SEL_W <= (1 << IDX_W))
         else $error("index width too narrow for select field");
   end

   assign none = ~|sel;

   if (TZ_TREE) begin : g_tree
      // isolate lowest set bit, then OR-reduce per index bit
      logic [SEL_W-1:0] lowbit;
      assign lowbit = sel & (~sel + SEL_W'(1));
      for (genvar gb = 0; gb < IDX_W; gb++) begin : g_bit
         logic [SEL_W-1:0] pick;
         for (genvar gi = 0; gi < SEL_W; gi++) begin : g_pos
            localparam logic [31:0] POS = gi;
            assign pick[gi] = lowbit[gi] & POS[gb];
         end
         assign idx[gb] = |pick;
      end
   end else begin : g_scan
      // priority scan from the top; lowest set bit is written last
      always_comb begin
         idx = '0;
         for (int i = SEL_W - 1; i >= 0; i--) begin
            if (sel[i]) idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/pcicfg_split.sv
// Joins offset and mapping half, decodes fields, builds type-0 address.
module pcicfg_split #(
   parameter int OFF_W   = 16,
   parameter int BUS_W   = 8,
   parameter int DEV_W   = 5,
   parameter int FN_W    = 3,
   parameter bit TZ_TREE = 1'b1
) (
   input  logic [OFF_W-1:0]   off,
   input  logic [OFF_W-1:0]   upper,
   input  logic               type1,
   input  logic [BUS_W-1:0]   bus,
   output logic [2*OFF_W-1:0] addr,
   output logic               bad
);

   localparam int ADDR_W = 2 * OFF_W;
   localparam int REG_W  = 8;
   localparam int FN_LO  = REG_W;
   localparam int SEL_LO = FN_LO + FN_W;
   localparam int SEL_W  = ADDR_W - SEL_LO;
   localparam int DEV_LO = SEL_LO;
   localparam int BUS_LO = DEV_LO + DEV_W;
   localparam int PAD_W  = ADDR_W - 1 - BUS_LO - BUS_W;

   initial begin
      assert (PAD_W >= 0)
         else $error("bus field does not fit below the enable bit");
   end

   logic [ADDR_W-1:0] work;
   logic [DEV_W-1:0]  dev;
   logic              sel_none;
   logic              unused_low;

   assign work = {upper, off};

   pcicfg_tz_enc #(
      .SEL_W  (SEL_W),
      .IDX_W  (DEV_W),
      .TZ_TREE(TZ_TREE)
   ) i_enc (
      .sel (work[ADDR_W-1:SEL_LO]),
      .idx (dev),
      .none(sel_none)
   );

   assign unused_low = ^work[1:0];
   assign bad = type1 | sel_none;

   if (PAD_W > 0) begin : g_pad
      assign addr = {1'b1, {PAD_W{1'b0}}, bus, dev,
                     work[FN_LO +: FN_W], work[REG_W-1:2], 2'b00};
   end else begin : g_nopad
      assign addr = {1'b1, bus, dev,
                     work[FN_LO +: FN_W], work[REG_W-1:2], 2'b00};
   end

endmodule

// File: rtl/pcicfg_fill.sv
// Width-sized all-ones response for refused reads.
module pcicfg_fill #(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        size,
   output logic [DATA_W-1:0] data
);

   import pcicfg_pkg::*;

   localparam int LANES = DATA_W / 8;

   initial begin
      assert (DATA_W == 32)
         else $error("fill supports 1, 2 and 4 byte accesses only");
   end

   logic [LANES-1:0] lane_on;

   always_comb begin
      unique case (acc_size_e'(size))
         SZ_BYTE: lane_on = LANES'(1);
         SZ_HALF: lane_on = LANES'(3);
         default: lane_on = '1;
      endcase
   end

   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      assign data[gl*8 +: 8] = {8{lane_on[gl]}};
   end

endmodule

// File: rtl/pcicfg_xlate.sv
module pcicfg_xlate #(
   parameter int OFF_W   = 16,
   parameter int BUS_W   = 8,
   parameter int DEV_W   = 5,
   parameter int FN_W    = 3,
   parameter int DATA_W  = 32,
   parameter bit TZ_TREE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_vld,
   input  logic                 acc_wr,
   input  logic [OFF_W-1:0]     acc_off,
   input  logic [1:0]           acc_size,
   input  logic [OFF_W-1:0]     map_upper,
   input  logic                 map_type1,
   input  logic [BUS_W-1:0]     bus_num,
   output logic                 cfg_vld,
   output logic                 cfg_wr,
   output logic [2*OFF_W-1:0]   cfg_addr,
   output logic                 fill_vld,
   output logic [DATA_W-1:0]    fill_data,
   output logic                 abort_clr
);

   import pcicfg_pkg::*;

   localparam int ADDR_W = 2 * OFF_W;

   logic [ADDR_W-1:0] xl_addr;
   logic              xl_bad;
   logic [DATA_W-1:0] ones;
   logic              take;
   outcome_t          nxt, cur;

   pcicfg_split #(
      .OFF_W  (OFF_W),
      .BUS_W  (BUS_W),
      .DEV_W  (DEV_W),
      .FN_W   (FN_W),
      .TZ_TREE(TZ_TREE)
   ) i_split (
      .off  (acc_off),
      .upper(map_upper),
      .type1(map_type1),
      .bus  (bus_num),
      .addr (xl_addr),
      .bad  (xl_bad)
   );

   pcicfg_fill #(
      .DATA_W(DATA_W)
   ) i_fill (
      .size(acc_size),
      .data(ones)
   );

   assign take = acc_vld & ~xl_bad;

   always_comb begin
      nxt.cfg  = take;
      nxt.fill = acc_vld & xl_bad & ~acc_wr;
      nxt.clr  = take;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur       <= '0;
         cfg_wr    <= 1'b0;
         cfg_addr  <= '0;
         fill_data <= '0;
      end else begin
         cur <= nxt;
         if (take) begin
            cfg_wr   <= acc_wr;
            cfg_addr <= xl_addr;
         end
         if (nxt.fill) fill_data <= ones;
      end
   end

   assign cfg_vld   = cur.cfg;
   assign fill_vld  = cur.fill;
   assign abort_clr = cur.clr;

endmodule

// File: rtl/pcicfg_xlate_chk.sv
module pcicfg_xlate_chk #(
   parameter int OFF_W  = 16,
   parameter int BUS_W  = 8,
   parameter int DEV_W  = 5,
   parameter int FN_W   = 3,
   parameter int DATA_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               acc_vld,
   input logic               acc_wr,
   input logic [OFF_W-1:0]   acc_off,
   input logic               map_type1,
   input logic [BUS_W-1:0]   bus_num,
   input logic               cfg_vld,
   input logic               cfg_wr,
   input logic [2*OFF_W-1:0] cfg_addr,
   input logic               fill_vld,
   input logic [DATA_W-1:0]  fill_data,
   input logic               abort_clr
);

   localparam int FN_LO  = 8;
   localparam int BUS_LO = FN_LO + FN_W + DEV_W;

   AST_ENABLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_vld |-> cfg_addr[2*OFF_W-1] && cfg_addr[1:0] == 2'b00); // R3

   AST_FUNC_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_vld |-> cfg_addr[FN_LO +: FN_W] == $past(acc_off[FN_LO +: FN_W])); // R3

   AST_BUS_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_vld |-> cfg_addr[BUS_LO +: BUS_W] == $past(bus_num)); // R4

   AST_TYPE1_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && map_type1) |=> !cfg_vld && !abort_clr); // R5

   AST_BAD_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      fill_vld |-> $past(acc_vld && !acc_wr)); // R7

   AST_FILL_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      fill_vld |-> fill_data[7:0] == 8'hFF && !cfg_vld); // R8

   AST_CLR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      abort_clr == cfg_vld); // R9

   AST_DIR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_vld |-> $past(acc_vld) && cfg_wr == $past(acc_wr)); // R10

endmodule

bind pcicfg_xlate pcicfg_xlate_chk #(
   .OFF_W (OFF_W),
   .BUS_W (BUS_W),
   .DEV_W (DEV_W),
   .FN_W  (FN_W),
   .DATA_W(DATA_W)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .acc_vld  (acc_vld),
   .acc_wr   (acc_wr),
   .acc_off  (acc_off),
   .map_type1(map_type1),
   .bus_num  (bus_num),
   .cfg_vld  (cfg_vld),
   .cfg_wr   (cfg_wr),
   .cfg_addr (cfg_addr),
   .fill_vld (fill_vld),
   .fill_data(fill_data),
   .abort_clr(abort_clr)
);

// File: tb/test_pcicfg_xlate.sv
module test_pcicfg_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_vld = 1'b0;
   logic        acc_wr = 1'b0;
   logic [15:0] acc_off = '0;
   logic [1:0]  acc_size = '0;
   logic [15:0] map_upper = '0;
   logic        map_type1 = 1'b0;
   logic [7:0]  bus_num = '0;
   logic        cfg_vld, cfg_wr, fill_vld, abort_clr;
   logic [31:0] cfg_addr, fill_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic        e_cfg = 1'b0, e_fill = 1'b0, e_wr = 1'b0;
   logic [31:0] e_addr = '0, e_data = '0;
   string       e_tag = "R10";
   logic [31:0] lcg = 32'h1234_5678;

   always #5 clk = ~clk;

   pcicfg_xlate i_pcicfg_xlate (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
      .acc_off(acc_off), .acc_size(acc_size), .map_upper(map_upper),
      .map_type1(map_type1), .bus_num(bus_num), .cfg_vld(cfg_vld),
      .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .fill_vld(fill_vld),
      .fill_data(fill_data), .abort_clr(abort_clr)
   );

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      return s * 32'd1664525 + 32'd1013904223;
   endfunction

   task automatic check_now();
      checks++;
      if ({cfg_vld, fill_vld, abort_clr} !== {e_cfg, e_fill, e_cfg}) begin
         failures++;
         $display("FAIL %s pulses act=%b exp=%b", e_tag,
                  {cfg_vld, fill_vld, abort_clr}, {e_cfg, e_fill, e_cfg});
      end
      if (e_cfg) begin
         checks++;
         if ({cfg_wr, cfg_addr} !== {e_wr, e_addr}) begin
            failures++;
            $display("FAIL %s wr/addr act=%b/%h exp=%b/%h", e_tag,
                     cfg_wr, cfg_addr, e_wr, e_addr);
         end
      end
      if (e_fill) begin
         checks++;
         if (fill_data !== e_data) begin
            failures++;
            $display("FAIL %s fill act=%h exp=%h", e_tag, fill_data, e_data);
         end
      end
   endtask

   // checks the previous cycle's access, then presents a new one
   task automatic step(input bit v, input bit w, input logic [15:0] off,
                       input logic [15:0] up, input bit t1,
                       input logic [1:0] sz, input string tag);
      logic [31:0] c;
      logic [4:0]  dev;
      bit          bad;
      @(negedge clk);
      check_now();
      acc_vld = v; acc_wr = w; acc_off = off; map_upper = up;
      map_type1 = t1; acc_size = sz;
      c = {up, off};
      bad = t1 || (c[31:11] == 21'd0);
      dev = '0;
      for (int i = 20; i >= 0; i--) if (c[11 + i]) dev = 5'(i);
      e_cfg  = v && !bad;
      e_fill = v && bad && !w;
      e_tag  = v ? tag : "R10 idle";
      if (e_cfg) begin
         e_wr   = w;
         e_addr = {1'b1, 7'd0, bus_num, dev, c[10:8], c[7:2], 2'b00};
      end
      if (e_fill)
         e_data = (sz == 2'd0) ? 32'h0000_00FF :
                  (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;  // R1 during reset
      if ({cfg_vld, fill_vld, abort_clr} !== 3'b000) begin
         failures++;
         $display("FAIL R1 reset pulses act=%b exp=000", {cfg_vld, fill_vld, abort_clr});
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      checks++;  // R1 after release
      if ({cfg_vld, fill_vld, abort_clr} !== 3'b000) begin
         failures++;
         $display("FAIL R1 post-reset pulses act=%b exp=000", {cfg_vld, fill_vld, abort_clr});
      end

      // R2 R3 R4 R9: every single-bit select position with every function,
      // back to back, interleaved with refused reads of rotating width (R8)
      for (int b = 0; b < 2; b++) begin
         bus_num = (b == 0) ? 8'h00 : 8'hA5;
         for (int p = 0; p < 21; p++) begin
            for (int f = 0; f < 8; f++) begin
               logic [31:0] c;
               lcg = next_rand(lcg);
               c = (32'd1 << (11 + p)) | (32'(f) << 8) | {24'd0, lcg[7:0]};
               step(1'b1, lcg[9], c[15:0], c[31:16], 1'b0, lcg[11:10],
                    "R2/R3/R4/R9 sweep");
               step(1'b1, 1'b0, {5'd0, lcg[18:8]}, 16'd0, 1'b0, 2'(f % 4),
                    "R6/R8 empty select read");
            end
         end
         step(1'b0, 1'b0, 16'd0, 16'd0, 1'b0, 2'd0, "R10");
      end

      // R11: several select bits set, lowest decides
      for (int k = 0; k < 200; k++) begin
         lcg = next_rand(lcg);
         step(1'b1, k[0], lcg[15:0] | 16'h0800, lcg[31:16], 1'b0, 2'd2,
              "R11 multi-select");
      end

      // R5: type-1 requests, reads and writes, any address
      for (int k = 0; k < 40; k++) begin
         lcg = next_rand(lcg);
         step(1'b1, k[0], lcg[15:0], lcg[31:16] | 16'h0001, 1'b1, 2'(k % 4),
              k[0] ? "R5/R7 type-1 write" : "R5/R8 type-1 read");
         step(1'b1, 1'b1, 16'h0800, 16'h0000, 1'b0, 2'd2, "R9 after type-1");
      end

      // R7: refused writes produce nothing, also after a valid access
      for (int k = 0; k < 20; k++) begin
         lcg = next_rand(lcg);
         step(1'b1, 1'b0, 16'hF800, 16'h8000, 1'b0, 2'd0, "R10 before bad write");
         step(1'b1, 1'b1, {5'd0, lcg[10:0]}, 16'd0, 1'b0, 2'(k % 4), "R6/R7 empty write");
         step(1'b1, 1'b1, {5'd0, lcg[10:0]}, 16'd0, 1'b1, 2'd2, "R5/R6/R7 both faults write");
         step(1'b1, 1'b0, {5'd0, lcg[10:0]}, 16'd0, 1'b1, 2'd1, "R5/R6/R8 both faults read");
      end

      // R10: idle gaps after pulses
      step(1'b1, 1'b0, 16'h1000, 16'h0000, 1'b0, 2'd2, "R10");
      step(1'b0, 1'b1, 16'h1000, 16'h0000, 1'b0, 2'd2, "R10");
      step(1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 2'd0, "R10");
      step(1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 2'd0, "R10");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule